// File: doc/BRIEF.md
# Framed SPI Register Slave

This block is the serial front end of a register-mapped peripheral. A host talks to it over a four-wire SPI link in mode 0. Every transaction sits inside one low period of chip select, and chip select must go high again between transactions. The first 32 bits of a frame are a command word: an opcode, a 16-bit byte address and a word count. After the command word come that many 32-bit data words, which go to or come from consecutive word addresses. The address steps by four bytes for each data word.

The slave counts the serial clock edges in each frame and checks them when chip select rises. A frame is rejected if the total is not a whole number of 32-bit words, if it has no data words, or if its length does not agree with the word count. A rejected frame sets a sticky error flag. Its writes never reach the registers, because write data is held in a staging copy and is only committed at the end of a good frame. At the start of every frame the slave shifts out a status byte. That byte carries the error flag and the external fault inputs, so the host learns on each access whether the previous frame has to be repeated.

All SPI inputs are sampled through synchronisers in the system clock domain. The serial clock must therefore be several times slower than `clk`.

Top module: `spi_frame_slave`

## Requirements
- R1: SPI mode 0, MSB first. SDI is taken on each rising SCLK edge and SDO moves after each falling edge. A word written to a register reads back unchanged in a later read frame.
- R2: Command word layout: bits [31:24] are the opcode (0x61 write, 0x41 read), bits [23:8] are the byte address and bits [7:0] are the word count. A count of 0 means 256 words.
- R3: In a burst, data word k (k counted from 1) goes to or comes from byte address start + 4*(k-1), modulo 2^16.
- R4: When chip select rises after a bit count that is not a multiple of 32, `spi_err` is set.
- R5: A frame of zero bits, a command-only frame, and a frame whose word total differs from count+1 each set `spi_err`.
- R6: A write frame that ends with a framing error leaves every register unchanged.
- R7: `spi_err` stays set until a good write frame writes a 1 to bit 0 at byte address 0x0100. Reading that address returns `spi_err` in bit 0 and zeros elsewhere.
- R8: From chip select falling, SDO gives the status byte {spi_err, fault_in[6:0]}, MSB first. The remaining 24 bits of the command word period are 0.
- R9: `sdo_oe` is high while chip select is low and low while it is high.
- R10: After reset, all registers read 0, `spi_err` is 0 and `sdo_oe` is 0.
- R11: If a frame writes the clear bit but has a framing error, `spi_err` stays set.
- R12: Byte addresses outside 0x0000-0x003F and other than 0x0100 read as 0, and writes to them are ignored.
- R13: An opcode other than 0x61 or 0x41 changes no register, and SDO is 0 after the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI serial clock, idle low |
| cs_n | input | 1 | SPI chip select, active low |
| sdi | input | 1 | Serial data from the host |
| fault_in | input | 7 | External fault flags placed in the status byte |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| spi_err | output | 1 | Sticky framing error flag |

## Verification
Two functions meet on the same chip-select rising edge: setting the error flag for a bad frame, and clearing it through a write to the interrupt register. The bench provokes this with a frame that writes 1 to the clear bit and then adds one word too many. It judges the result by `spi_err` after the frame and by the status byte of the next frame, and both must still show the flag. A second meeting point is the frame that reads the interrupt register: its status byte and its data word must both report the flag value from before that frame.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
    localparam logic [7:0] OP_WRITE = 8'h61;
    localparam logic [7:0] OP_READ  = 8'h41;

    typedef struct packed {
        logic [7:0]  op;
        logic [15:0] addr;
        logic [7:0]  len;
    } cmd_word_t;

    typedef struct packed {
        logic [30:0] rx;
        logic [31:0] tx;
        logic [4:0]  bit_cnt;
        logic [8:0]  word_cnt;
        logic [7:0]  op;
        logic [7:0]  len;
        logic [15:0] wr_ptr;
        logic [15:0] rd_ptr;
        logic        clr_req;
        logic        err;
        logic        sclk_p;
        logic        cs_p;
    } frame_st_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            logic [W-1:0] stg_d;
            if (g == 0) begin : g_first
                assign stg_d = d;
            end else begin : g_next
                assign stg_d = stg_q[g-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d;
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx,
    output logic [31:0]   rd_data,
    input  logic          stage_we,
    input  logic [AW-1:0] stage_idx,
    input  logic [31:0]   stage_data,
    input  logic          stage_clr,
    input  logic          commit
);
    typedef struct packed {
        logic [DEPTH-1:0][31:0] mem;
        logic [DEPTH-1:0][31:0] shadow;
        logic [DEPTH-1:0]       dirty;
    } bank_st_t;

    bank_st_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (stage_clr) begin
            r_d.dirty = '0;
        end
        if (stage_we) begin
            r_d.shadow[stage_idx] = stage_data;
            r_d.dirty[stage_idx]  = 1'b1;
        end
        if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (r_q.dirty[i]) r_d.mem[i] = r_q.shadow[i];
            end
            r_d.dirty = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.mem[rd_idx];

    AST_MEM_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(r_q.mem)); // R6
endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
    import spi_frame_pkg::*;
#(
    parameter int          DEPTH       = 16,
    parameter int          FAULT_W     = 7,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] INT_ADDR    = 16'h0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               sdi,
    input  logic [FAULT_W-1:0] fault_in,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               spi_err
);
    localparam int          AW       = $clog2(DEPTH);
    localparam int          STAT_W   = FAULT_W + 1;
    localparam int          PAD_W    = 32 - STAT_W;
    localparam logic [13:0] INT_WORD = INT_ADDR[15:2];
    localparam logic [13:0] ARR_END  = 14'(DEPTH);

    logic [2:0] pins_s;
    logic       sclk_s, cs_s, sdi_s;

    spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, sdi}), .q(pins_s)
    );
    assign {sclk_s, cs_s, sdi_s} = pins_s;

    frame_st_t r_d, r_q;

    logic          stage_we, stage_clr, commit;
    logic [AW-1:0] stage_idx, rd_idx;
    logic [31:0]   stage_data, bank_rd, rd_val, rx_word;
    logic          cs_fall, cs_rise, sclk_rise, sclk_fall, frame_err;
    logic [8:0]    exp_words;
    cmd_word_t     cmd_in;

    spi_reg_bank #(.DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_data(bank_rd),
        .stage_we(stage_we), .stage_idx(stage_idx), .stage_data(stage_data),
        .stage_clr(stage_clr), .commit(commit)
    );

    assign cs_fall   = !cs_s && r_q.cs_p;
    assign cs_rise   = cs_s && !r_q.cs_p;
    assign sclk_rise = !cs_s && sclk_s && !r_q.sclk_p;
    assign sclk_fall = !cs_s && !sclk_s && r_q.sclk_p;
    assign rx_word   = {r_q.rx, sdi_s};
    assign cmd_in    = cmd_word_t'(rx_word);
    assign exp_words = (r_q.len == 8'd0) ? 9'd257 : ({1'b0, r_q.len} + 9'd1);
    assign frame_err = (r_q.bit_cnt != 5'd0) || (r_q.word_cnt == 9'd0)
                    || (r_q.word_cnt != exp_words);
    assign rd_idx    = r_q.rd_ptr[AW+1:2];

    always_comb begin
        if (r_q.rd_ptr[15:2] < ARR_END)        rd_val = bank_rd;
        else if (r_q.rd_ptr[15:2] == INT_WORD) rd_val = {31'd0, r_q.err};
        else                                   rd_val = '0;
    end

    always_comb begin
        r_d        = r_q;
        r_d.sclk_p = sclk_s;
        r_d.cs_p   = cs_s;
        stage_we   = 1'b0;
        stage_clr  = 1'b0;
        commit     = 1'b0;
        stage_idx  = r_q.wr_ptr[AW+1:2];
        stage_data = rx_word;
        if (cs_fall) begin
            r_d.tx       = {r_q.err, fault_in, {PAD_W{1'b0}}};
            r_d.bit_cnt  = '0;
            r_d.word_cnt = '0;
            r_d.clr_req  = 1'b0;
            stage_clr    = 1'b1;
        end else if (sclk_rise) begin
            r_d.rx      = rx_word[30:0];
            r_d.bit_cnt = r_q.bit_cnt + 5'd1;
            if (r_q.bit_cnt == 5'd31) begin
                if (r_q.word_cnt != '1) r_d.word_cnt = r_q.word_cnt + 9'd1;
                if (r_q.word_cnt == 9'd0) begin
                    r_d.op     = cmd_in.op;
                    r_d.len    = cmd_in.len;
                    r_d.wr_ptr = cmd_in.addr;
                    r_d.rd_ptr = cmd_in.addr;
                end else if (r_q.op == OP_WRITE) begin
                    if (r_q.wr_ptr[15:2] < ARR_END) stage_we = 1'b1;
                    if (r_q.wr_ptr[15:2] == INT_WORD) r_d.clr_req = rx_word[0];
                    r_d.wr_ptr = r_q.wr_ptr + 16'd4;
                end
            end
        end else if (sclk_fall) begin
            if (r_q.bit_cnt == 5'd0 && r_q.word_cnt != 9'd0 && r_q.op == OP_READ) begin
                r_d.tx     = rd_val;
                r_d.rd_ptr = r_q.rd_ptr + 16'd4;
            end else begin
                r_d.tx = {r_q.tx[30:0], 1'b0};
            end
        end else if (cs_rise) begin
            if (frame_err) begin
                r_d.err = 1'b1;
            end else if (r_q.op == OP_WRITE) begin
                commit = 1'b1;
                if (r_q.clr_req) r_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.cs_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_oe  = !cs_s;
    assign sdo     = sdo_oe ? r_q.tx[31] : 1'b0;
    assign spi_err = r_q.err;

    AST_ERR_ON_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && frame_err |=> spi_err); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        spi_err && !cs_rise |=> spi_err); // R7
    AST_ERR_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && frame_err && r_q.clr_req |=> spi_err); // R11
    AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> sdo_oe && (sdo == $past(spi_err))); // R8
    AST_NO_COMMIT_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise && frame_err |-> !commit); // R6
endmodule

// File: tb/spi_frame_slave_test.sv
module spi_frame_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 5;
    localparam int WATCHDOG   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
    logic [6:0] fault_v = 7'h00;
    logic       sdo, sdo_oe, spi_err;

    spi_frame_slave uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
        .fault_in(fault_v), .sdo(sdo), .sdo_oe(sdo_oe), .spi_err(spi_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] m_regs [16];
    logic        m_err = 1'b0;
    bit          fb [$];

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(input logic [15:0] a);
        if (a[15:2] < 14'd16)        return m_regs[a[5:2]];
        else if (a[15:2] == 14'd64)  return {31'd0, m_err};
        else                         return 32'd0;
    endfunction

    task automatic push_word(input logic [31:0] w);
        for (int i = 31; i >= 0; i--) fb.push_back(w[i]);
    endtask

    function automatic logic [31:0] fb_word(input int k);
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[31-i] = fb[k*32+i];
        return w;
    endfunction

    // Drives the bits in fb as one frame, checks SDO bit by bit, then updates the model.
    task automatic run_frame(input string tag);
        int          n = fb.size();
        logic [31:0] cw = 32'd0;
        logic [7:0]  stat = {m_err, fault_v};
        logic        exp_b;
        int          words, exp_words;
        bit          ferr, clr;
        logic [15:0] a;
        if (n >= 32) cw = fb_word(0);
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            sdi = fb[i];
            repeat (HP) @(negedge clk);
            if (i < 8)                 exp_b = stat[7-i];
            else if (i < 32)           exp_b = 1'b0;
            else if (cw[31:24] == 8'h41) begin
                a = cw[23:8] + 16'(4 * (i/32 - 1));
                exp_b = mread(a) >> (31 - i%32);
            end else                   exp_b = 1'b0;
            chk({tag, " R1 R8 sdo bit"}, 32'(sdo), 32'(exp_b));
            if (i == 0) chk({tag, " R9 sdo_oe in frame"}, 32'(sdo_oe), 32'd1);
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        words     = n / 32;
        exp_words = ((cw[7:0] == 8'd0) ? 256 : int'(cw[7:0])) + 1;
        ferr      = (n < 32) || (n % 32 != 0) || (words != exp_words);
        clr       = 1'b0;
        if (ferr) m_err = 1'b1;
        else if (cw[31:24] == 8'h61) begin
            for (int k = 1; k < words; k++) begin
                a = cw[23:8] + 16'(4 * (k - 1));
                if (a[15:2] < 14'd16) m_regs[a[5:2]] = fb_word(k);
                else if (a[15:2] == 14'd64) clr = fb_word(k)[0];
            end
            if (clr) m_err = 1'b0;
        end
        chk({tag, " R4 R5 R7 spi_err after frame"}, 32'(spi_err), 32'(m_err));
        chk({tag, " R9 sdo_oe idle"}, 32'(sdo_oe), 32'd0);
        fb.delete();
    endtask

    task automatic wr1(input logic [15:0] a, input logic [31:0] d, input string tag);
        push_word({8'h61, a, 8'd1});
        push_word(d);
        run_frame(tag);
    endtask

    task automatic rd(input logic [15:0] a, input int cnt, input string tag);
        push_word({8'h41, a, 8'(cnt)});
        for (int k = 0; k < cnt; k++) push_word(32'h0);
        run_frame(tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_regs[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 spi_err at reset", 32'(spi_err), 32'd0);
        chk("R10 sdo_oe at reset", 32'(sdo_oe), 32'd0);
        rd(16'h0000, 16, "R10 registers zero");

        fault_v = 7'h2B;
        wr1(16'h000C, 32'hA5C3_0F81, "R1 R2 single write");
        rd(16'h000C, 1, "R1 R2 single read");

        push_word({8'h61, 16'h0010, 8'd4});
        for (int k = 0; k < 4; k++) push_word(32'h1111_0000 + 32'(k * 32'h0101));
        run_frame("R3 burst write");
        rd(16'h000C, 5, "R3 burst read");
        push_word({8'h61, 16'hFFFC, 8'd2});
        push_word(32'hDEAD_0001);
        push_word(32'hBEEF_0002);
        run_frame("R3 address wrap write");
        rd(16'h0000, 1, "R3 address wrap read");

        // R4 R6: bit count not a multiple of 32
        push_word({8'h61, 16'h0004, 8'd1});
        push_word(32'h7777_7777);
        for (int i = 0; i < 8; i++) fb.push_back(1'b1);
        run_frame("R4 R6 long ragged frame");
        push_word({8'h61, 16'h0008, 8'd1});
        for (int i = 0; i < 20; i++) fb.push_back(1'b1);
        run_frame("R4 R6 short ragged frame");
        rd(16'h0004, 2, "R6 R8 discarded data and status");
        rd(16'h0100, 1, "R7 interrupt reg read");

        wr1(16'h0100, 32'h0000_0001, "R7 clear");
        chk("R7 cleared", 32'(spi_err), 32'd0);

        // R5: command-only, mismatch and empty frames
        push_word({8'h61, 16'h0000, 8'd1});
        run_frame("R5 command only");
        wr1(16'h0100, 32'h1, "R7 clear again");
        push_word({8'h61, 16'h0000, 8'd2});
        push_word(32'h5555_AAAA);
        run_frame("R5 R6 length mismatch");
        rd(16'h0000, 1, "R6 mismatch discarded");
        rd(16'h0000, 1, "R7 sticky across reads");
        wr1(16'h0100, 32'h1, "R7 clear third");
        run_frame("R5 empty frame");

        // R11: clear request inside an errored frame
        push_word({8'h61, 16'h0100, 8'd1});
        push_word(32'h1);
        push_word(32'h1);
        run_frame("R11 clear with error");
        chk("R11 still set", 32'(spi_err), 32'd1);
        rd(16'h0100, 1, "R11 status next frame");
        wr1(16'h0100, 32'h1, "R7 clear fourth");

        // R12 and R13
        wr1(16'h0200, 32'hFFFF_FFFF, "R12 unmapped write");
        rd(16'h0200, 1, "R12 unmapped read");
        fault_v = 7'h55;
        push_word({8'h33, 16'h0000, 8'd1});
        push_word(32'hCAFE_F00D);
        run_frame("R13 unknown opcode");
        rd(16'h0000, 2, "R13 R8 registers unchanged");

        // R2: count 0 means 256 words
        push_word({8'h61, 16'h0000, 8'd0});
        for (int k = 0; k < 256; k++) push_word(32'h0300_0000 + 32'(k * 2));
        run_frame("R2 count zero write");
        rd(16'h0000, 16, "R2 count zero readback");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule